// File: doc/BRIEF.md
# MSI Capture Ring-Buffer Controller

This block catches message-signalled interrupt writes and turns each one into a 16-byte record. It stores every record in a circular queue that sits in system memory. The interrupt number from the message data goes into the first little-endian 32-bit word of the record. The other twelve bytes are written as zero. The record is sent out as a single memory-write request, placed at the 64-bit queue base plus the current write offset.

Software sets the block up through a small word-addressed register port. That port holds a control word, two halves of the queue base address, a read offset that software moves forward as it drains records, and a write offset that hardware moves forward. A 2-bit code selects the queue size. An interrupt level stays high while the queue holds unread records. Full detection is optional. When it is on, the block can either drop new messages and set a sticky flag, or overwrite the oldest record and move the read offset forward.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `mem_req_valid` is low and `msg_ready` is high.
- R2: Register word addresses are: 0 control, 3 base high, 4 base low, 5 read offset, 6 write offset. The write offset is read-only. Addresses 1, 2 and 7 read zero and ignore writes.
- R3: A captured record is requested at address {base high, base low} + write offset, with a full 64-bit add. Request data bits 15:0 carry the message number and bits 127:16 are zero.
- R4: The write offset changes only when a memory request completes, which is the cycle where `mem_req_valid` and `mem_req_ready` are both high. It then advances by 16 and wraps to zero at the queue size. Its readback is masked to the queue size.
- R5: Control bits 9:8 hold a size code c. The queue size is 2^(MIN_SHIFT+c) bytes, and MIN_SHIFT defaults to 15.
- R6: A write to the read offset is stored with bits 3:0 cleared and bits at or above the queue size cleared. The readback is masked the same way.
- R7: While control bit 0 (capture enable) is clear, messages are accepted and discarded: no memory request is made and the offsets do not change.
- R8: With control bit 1 (full detect) set, the queue is full when the write offset plus 16, wrapped, equals the read offset. A message that arrives while the queue is full sets the sticky flag at control bit 7. If control bit 4 (stop on full) is also set, that message is dropped. Writing control with bit 7 set clears the flag.
- R9: With full detect set and stop on full clear, a message that arrives while the queue is full is still written. When its request completes, the read offset also advances by 16.
- R10: With full detect clear, the queue is never treated as full, and the write offset may run past the read offset.
- R11: `irq` equals control bit 0 AND control bit 3 AND (read offset differs from write offset).
- R12: At most one memory request is outstanding. `msg_ready` is low from acceptance until the request completes, and the request address and data stay stable while they wait for `mem_req_ready`.
- R13: Clearing capture enable while a request is pending does not cancel it. The request still completes and the write offset still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| msg_valid | input | 1 | Inbound message present |
| msg_ready | output | 1 | Block can take a message |
| msg_num | input | 16 | Interrupt number carried by the message |
| mem_req_valid | output | 1 | Memory write request pending |
| mem_req_ready | input | 1 | Memory side takes the request |
| mem_req_addr | output | 64 | Byte address of the record |
| mem_req_data | output | 128 | Record contents, byte 0 in bits 7:0 |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench uses a reduced minimum size, so that every size code can be wrapped twice. Each message number is distinct, which separates a wrong record from a repeated one. A base address near a 32-bit boundary exposes a truncated address add. The read offset is set equal to, one behind and exactly full against the write offset. These cases separate the empty, non-full and full decisions under each full-handling mode. Requests are held off for several cycles, with and without capture being disabled in the middle. This shows that acceptance stays blocked, that the request stays stable, and that a pending record still completes.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

  localparam int REG_AW   = 3;
  localparam int REG_DW   = 32;
  localparam int NUM_W    = 16;
  localparam int BASE_W   = 64;
  localparam int REC_BITS = 128;
  localparam int REC_STEP = 16;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_BHI   = 3'd3;
  localparam logic [REG_AW-1:0] RA_BLO   = 3'd4;
  localparam logic [REG_AW-1:0] RA_RDOFF = 3'd5;
  localparam logic [REG_AW-1:0] RA_WROFF = 3'd6;

  localparam int CB_EN     = 0;
  localparam int CB_FD     = 1;
  localparam int CB_IRQ    = 3;
  localparam int CB_STOP   = 4;
  localparam int CB_STICKY = 7;
  localparam int CB_SIZE   = 8;

  typedef struct packed {
    logic [1:0] size;
    logic       stop;
    logic       irq_en;
    logic       fd;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [OFF_W-1:0]  rd_m,
  input  logic [OFF_W-1:0]  wr_m,
  input  logic              full_set,
  output ctrl_t             ctrl,
  output logic [BASE_W-1:0] base,
  output logic              rd_we
);

  ctrl_t             ctrl_q, ctrl_d;
  logic              sticky_q, sticky_d;
  logic [REG_DW-1:0] bhi_q, bhi_d, blo_q, blo_d;
  logic              ctrl_we;

  assign ctrl_we = reg_we && (reg_addr == RA_CTRL);
  assign rd_we   = reg_we && (reg_addr == RA_RDOFF);

  always_comb begin
    ctrl_d   = ctrl_q;
    bhi_d    = bhi_q;
    blo_d    = blo_q;
    sticky_d = sticky_q;
    if (ctrl_we) begin
      ctrl_d.en     = reg_wdata[CB_EN];
      ctrl_d.fd     = reg_wdata[CB_FD];
      ctrl_d.irq_en = reg_wdata[CB_IRQ];
      ctrl_d.stop   = reg_wdata[CB_STOP];
      ctrl_d.size   = reg_wdata[CB_SIZE+1:CB_SIZE];
      if (reg_wdata[CB_STICKY]) sticky_d = 1'b0;
    end
    if (full_set) sticky_d = 1'b1;
    if (reg_we && (reg_addr == RA_BHI)) bhi_d = reg_wdata;
    if (reg_we && (reg_addr == RA_BLO)) blo_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sticky_q <= 1'b0;
      bhi_q    <= '0;
      blo_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      sticky_q <= sticky_d;
      bhi_q    <= bhi_d;
      blo_q    <= blo_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]               = ctrl_q.en;
        reg_rdata[CB_FD]               = ctrl_q.fd;
        reg_rdata[CB_IRQ]              = ctrl_q.irq_en;
        reg_rdata[CB_STOP]             = ctrl_q.stop;
        reg_rdata[CB_STICKY]           = sticky_q;
        reg_rdata[CB_SIZE+1:CB_SIZE]   = ctrl_q.size;
      end
      RA_BHI:   reg_rdata = bhi_q;
      RA_BLO:   reg_rdata = blo_q;
      RA_RDOFF: reg_rdata = REG_DW'(rd_m);
      RA_WROFF: reg_rdata = REG_DW'(wr_m);
      default:  reg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign base = {bhi_q, blo_q};

  // R8: the sticky flag only rises after a full hit was reported
  p_sticky_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q) |-> $past(full_set));

endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int OFF_W     = MIN_SHIFT + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size,
  input  logic             rd_we,
  input  logic [OFF_W-1:0] rd_wdata,
  input  logic             adv,
  input  logic             bump,
  output logic [OFF_W-1:0] rd_m,
  output logic [OFF_W-1:0] wr_m,
  output logic [OFF_W-1:0] wr_next
);

  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(REC_STEP - 1);
  localparam logic [OFF_W-1:0] STEP       = OFF_W'(REC_STEP);

  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] rd_q, rd_d, wr_q, wr_d;

  assign mask    = ({OFF_W{1'b1}} >> (2'd3 - size)) & ALIGN_MASK;
  assign rd_m    = rd_q & mask;
  assign wr_m    = wr_q & mask;
  assign wr_next = (wr_m + STEP) & mask;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (adv)       wr_d = wr_next;
    if (rd_we)     rd_d = rd_wdata & mask;
    else if (bump) rd_d = (rd_m + STEP) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  // R4: the write offset moves only on a completed request
  p_wr_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q != $past(wr_q)) |-> $past(adv));

endmodule

// File: rtl/msi_ring_wr.sv
module msi_ring_wr
  import msi_ring_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_t               ctrl,
  input  logic [BASE_W-1:0]   base,
  input  logic [OFF_W-1:0]    rd_m,
  input  logic [OFF_W-1:0]    wr_m,
  input  logic [OFF_W-1:0]    wr_next,
  input  logic                msg_valid,
  output logic                msg_ready,
  input  logic [NUM_W-1:0]    msg_num,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [BASE_W-1:0]   mem_req_addr,
  output logic [REC_BITS-1:0] mem_req_data,
  output logic                adv,
  output logic                bump,
  output logic                full_set
);

  logic              busy_q, busy_d;
  logic              ovw_q, ovw_d;
  logic [BASE_W-1:0] addr_q, addr_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic              accept, full_now, start, done;

  assign msg_ready = ~busy_q;
  assign accept    = msg_valid & ~busy_q;
  assign full_now  = ctrl.fd & (wr_next == rd_m);
  assign start     = accept & ctrl.en & ~(full_now & ctrl.stop);
  assign done      = busy_q & mem_req_ready;
  assign full_set  = accept & ctrl.en & full_now;
  assign adv       = done;
  assign bump      = done & ovw_q;

  always_comb begin
    busy_d = busy_q;
    ovw_d  = ovw_q;
    addr_d = addr_q;
    num_d  = num_q;
    if (start) begin
      busy_d = 1'b1;
      ovw_d  = full_now;
      addr_d = base + BASE_W'(wr_m);
      num_d  = msg_num;
    end else if (done) begin
      busy_d = 1'b0;
      ovw_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovw_q  <= 1'b0;
      addr_q <= '0;
      num_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ovw_q  <= ovw_d;
      addr_q <= addr_d;
      num_q  <= num_d;
    end
  end

  assign mem_req_valid = busy_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_data  = {{(REC_BITS-NUM_W){1'b0}}, num_q};

  // R12: a waiting request holds its contents
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

  // R7: a new request only starts while capture was enabled
  p_start_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(ctrl.en));

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  localparam int OFF_W    = MIN_SHIFT + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic                msg_valid,
  output logic                msg_ready,
  input  logic [NUM_W-1:0]    msg_num,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [BASE_W-1:0]   mem_req_addr,
  output logic [REC_BITS-1:0] mem_req_data,
  output logic                irq
);

  ctrl_t             ctrl;
  logic [BASE_W-1:0] base;
  logic              rd_we, adv, bump, full_set;
  logic [OFF_W-1:0]  rd_m, wr_m, wr_next;

  msi_ring_regs #(.OFF_W(OFF_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rd_m(rd_m), .wr_m(wr_m), .full_set(full_set),
    .ctrl(ctrl), .base(base), .rd_we(rd_we)
  );

  msi_ring_ptr #(.MIN_SHIFT(MIN_SHIFT), .OFF_W(OFF_W)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .size(ctrl.size), .rd_we(rd_we), .rd_wdata(reg_wdata[OFF_W-1:0]),
    .adv(adv), .bump(bump),
    .rd_m(rd_m), .wr_m(wr_m), .wr_next(wr_next)
  );

  msi_ring_wr #(.OFF_W(OFF_W)) wr_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl(ctrl), .base(base),
    .rd_m(rd_m), .wr_m(wr_m), .wr_next(wr_next),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_num(msg_num),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .adv(adv), .bump(bump), .full_set(full_set)
  );

  assign irq = ctrl.en & ctrl.irq_en & (rd_m != wr_m);

  // R12: after a completion no request is outstanding in the next cycle
  p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/msi_ring_ctrl_tb_top.sv
module msi_ring_ctrl_tb_top;

  localparam int MS = 6;

  logic         clk, rst_n;
  logic         reg_we;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         msg_valid, msg_ready;
  logic [15:0]  msg_num;
  logic         mem_req_valid, mem_req_ready;
  logic [63:0]  mem_req_addr;
  logic [127:0] mem_req_data;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench model
  int          ctrl_e = 0;
  int          rd_e = 0, wr_e = 0;
  bit          sticky_e = 0;
  logic [63:0] base_e = '0;

  msi_ring_ctrl #(.MIN_SHIFT(MS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_num(msg_num),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int msk();
    int c = (ctrl_e >> 8) & 3;
    return ((1 << (MS + c)) - 1) & ~15;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 0) begin
      ctrl_e = d & 32'h31B;
      if (d[7]) sticky_e = 0;
    end
    if (a == 3) base_e[63:32] = d;
    if (a == 4) base_e[31:0] = d;
    if (a == 5) rd_e = d & msk();
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    int m = msk();
    bit irq_e;
    rd_reg(3'd6, v);
    chk(v == (wr_e & m), {tag, " R4 wr offset"}, v, wr_e & m);
    rd_reg(3'd5, v);
    chk(v == (rd_e & m), {tag, " R6 rd offset"}, v, rd_e & m);
    rd_reg(3'd0, v);
    chk(v == (ctrl_e | (int'(sticky_e) << 7)), {tag, " R8 ctrl/sticky"}, v, ctrl_e | (int'(sticky_e) << 7));
    irq_e = ctrl_e[0] && ctrl_e[3] && ((rd_e & m) != (wr_e & m));
    chk(irq == irq_e, {tag, " R11 irq"}, irq, irq_e);
  endtask

  // send one message; stall = cycles to hold off mem_req_ready; kill clears enable mid-wait
  task automatic send(input logic [15:0] num, input int stall, input bit kill, input string tag);
    int  m = msk();
    bit  en = ctrl_e[0], fd = ctrl_e[1], stop = ctrl_e[4];
    bit  full = fd && ((((wr_e & m) + 16) & m) == (rd_e & m));
    bit  will_wr = en && !(full && stop);
    logic [63:0] a_e = base_e + 64'(wr_e & m);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1'b1; msg_num = num;
    @(negedge clk);
    msg_valid = 1'b0;
    if (en && full) sticky_e = 1;
    if (will_wr) begin
      chk(mem_req_valid == 1'b1, {tag, " R3 req valid"}, mem_req_valid, 1);
      chk(mem_req_addr == a_e, {tag, " R3 addr"}, mem_req_addr, a_e);
      chk(mem_req_data == {112'b0, num}, {tag, " R3 data"}, mem_req_data, {112'b0, num});
      chk(msg_ready == 1'b0, {tag, " R12 busy"}, msg_ready, 0);
      for (int i = 0; i < stall; i++) begin
        if (kill && i == 0) wr_reg(3'd0, ctrl_e & ~1);
        else @(negedge clk);
        chk(mem_req_valid && mem_req_addr == a_e && mem_req_data == {112'b0, num} && !msg_ready,
            {tag, " R12 hold"}, mem_req_addr, a_e);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, {tag, " R12 done"}, mem_req_valid, 0);
      wr_e = ((wr_e & m) + 16) & m;
      if (full) rd_e = ((rd_e & m) + 16) & m;
    end else begin
      chk(mem_req_valid == 1'b0, {tag, " R7 no req"}, mem_req_valid, 0);
    end
    check_state(tag);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_valid = 1'b0; msg_num = '0; mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(irq == 0 && mem_req_valid == 0 && msg_ready == 1, "R1 outputs", {irq, mem_req_valid, msg_ready}, 3'b001);

    // R2 register map
    wr_reg(3'd3, 32'h0000_0012);
    wr_reg(3'd4, 32'h8000_0000);
    rd_reg(3'd3, v); chk(v == 32'h12, "R2 base hi", v, 32'h12);
    rd_reg(3'd4, v); chk(v == 32'h8000_0000, "R2 base lo", v, 32'h8000_0000);
    wr_reg(3'd6, 32'h40);
    rd_reg(3'd6, v); chk(v == 0, "R2 wr offset read-only", v, 0);
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_reg(3'd1, v); chk(v == 0, "R2 reserved", v, 0);
    check_state("R2");

    // R7 capture disabled
    send(16'h0011, 0, 0, "R7 disabled");

    // R5/R4/R10 size sweep with full detect off, two wraps per size
    for (int c = 0; c < 4; c++) begin
      int recs = (1 << (MS + c)) / 16;
      wr_reg(3'd0, 32'h9 | (c << 8));
      if (c == 1) wr_reg(3'd4, 32'hFFFF_FFF0);
      for (int i = 0; i < 2 * recs + 1; i++)
        send(16'(i * 37 + c * 1000 + 1), 0, 0, "R5 R10 sweep");
      wr_reg(3'd5, wr_e & msk());
      check_state("R11 drained");
    end

    // R6 read offset alignment and size mask
    wr_reg(3'd0, 32'h9);
    wr_reg(3'd5, 32'h1F7);
    rd_reg(3'd5, v); chk(v == 32'h30, "R6 rd mask", v, 32'h30);

    // R8 full stop
    wr_reg(3'd0, 32'h1B);
    wr_reg(3'd5, wr_e & msk());
    for (int i = 0; i < 4; i++) send(16'(16'hA000 + i), 0, 0, "R8 fill");
    chk(sticky_e == 1, "R8 model sticky", sticky_e, 1);
    wr_reg(3'd0, 32'h1B | 32'h80);
    check_state("R8 clear");

    // R9 overwrite oldest
    wr_reg(3'd0, 32'h0B);
    send(16'hB001, 0, 0, "R9 overwrite");
    send(16'hB002, 0, 0, "R9 overwrite");

    // R11 irq enable off
    wr_reg(3'd0, 32'h01);
    check_state("R11 irq off");

    // R12 stall, R13 disable during pending
    wr_reg(3'd0, 32'h09);
    send(16'hC001, 3, 0, "R12 stall");
    send(16'hC002, 3, 1, "R13 kill");
    send(16'hC003, 0, 0, "R13 after kill");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule